// File: doc/BRIEF.md
# Character I/O and Interrupt Sequencer

This block links an accumulator CPU to one byte-wide input device and one byte-wide output device. Each direction has a data register and a status flag. The input flag means "a byte is waiting for the CPU". The output flag means "the device can take another byte". The CPU sends one-cycle strobes for six I/O instructions. The block answers with a skip request, the waiting input byte, and the captured output byte. On the device side each direction uses a valid/ready handshake.

The block also holds the interrupt enable and the pending-interrupt bit, and it runs the three-step interrupt cycle in place of a normal fetch. A request is raised only between instructions, meaning in a timing state above T2, and only while interrupts are enabled and at least one of the two flags is up. The cycle has three steps:
- T0 captures the program counter.
- T1 writes the captured value to the save location and loads the PC with that location.
- T2 loads the location after it, clears the enable and the pending bit, and clears the CPU sequence counter.

Top module: `iox_ctrl`

## Requirements
- R1: After reset the input flag is 0 (`dev_in_ready`=1), the output flag is 1 (`dev_out_valid`=0), interrupts are disabled and `int_cycle` is 0.
- R2: When the input flag is 0, a byte offered with `dev_in_valid` is loaded into the input register (`in_byte`) and the flag is set. While the flag is 1 (`dev_in_ready`=0), offered bytes are ignored and `in_byte` keeps its value.
- R3: An `op_inp` strobe clears the input flag one cycle later. `in_byte` keeps presenting the register value.
- R4: An `op_out` strobe loads `ac_lo` into the output register and clears the output flag, so that `dev_out_valid`=1 and `dev_out_data`=`ac_lo` on the next cycle. This holds even when the device accepts a previous byte in the same cycle.
- R5: When `dev_out_valid` and `dev_out_ready` are both 1, the output flag sets and `dev_out_valid` drops on the next cycle.
- R6: `skip_req` is combinational. It is 1 when `op_ski` is high with the input flag 1, or when `op_sko` is high with the output flag 1. Otherwise it is 0.
- R7: `op_ion` sets the interrupt enable and `op_iof` clears it. With the enable clear, raised flags never start an interrupt cycle.
- R8: The pending bit (`int_cycle`) is set at a clock edge only when `t_state` is 3 or higher, the enable is 1, and either flag is 1. It is never set in T0, T1 or T2.
- R9: While pending, T0 captures `pc_cur`. In T1, `save_we`=1, `save_addr`=0, `save_data` is the captured PC, `pc_load`=1 and `pc_load_val`=0.
- R10: While pending, T2 drives `pc_load`=1 with `pc_load_val`=1 and `seq_clr`=1. On the next cycle `int_cycle` is 0 and the enable is cleared, so raised flags do not start a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| t_state | input | SC_W | CPU timing state (value n means Tn) |
| op_inp | input | 1 | Input-transfer instruction strobe |
| op_out | input | 1 | Output-transfer instruction strobe |
| op_ski | input | 1 | Skip-on-input-flag strobe |
| op_sko | input | 1 | Skip-on-output-flag strobe |
| op_ion | input | 1 | Interrupt-enable-on strobe |
| op_iof | input | 1 | Interrupt-enable-off strobe |
| ac_lo | input | DATA_W | Low byte of the accumulator |
| pc_cur | input | ADDR_W | Current program counter |
| skip_req | output | 1 | Skip next instruction |
| in_byte | output | DATA_W | Input register contents |
| int_cycle | output | 1 | Interrupt cycle replaces fetch |
| save_we | output | 1 | Memory write of return address |
| save_addr | output | ADDR_W | Address of return-address save |
| save_data | output | ADDR_W | Return address to store |
| pc_load | output | 1 | Load PC with pc_load_val |
| pc_load_val | output | ADDR_W | Value for the PC |
| seq_clr | output | 1 | Clear the CPU sequence counter |
| dev_in_valid | input | 1 | Input device offers a byte |
| dev_in_data | input | DATA_W | Offered input byte |
| dev_in_ready | output | 1 | Input register free |
| dev_out_valid | output | 1 | Output byte pending |
| dev_out_data | output | DATA_W | Output register contents |
| dev_out_ready | input | 1 | Output device accepts the byte |

## Verification
The bench builds the block with its defaults: byte-wide data, 12-bit addresses, a 4-bit timing state and the save location at 0. The 4-bit timing state lets the bench drive T0, T1, T2 and several states above T2. This exercises the rule that a request may be raised only between instructions, at both edges of that window. Each of the two flags is made to trigger an interrupt cycle on its own. The run also covers a byte offered while the input register is full, and an output strobe that lands in the same cycle as a device acceptance.

// File: rtl/iox_pkg.sv
package iox_pkg;

    localparam int IOX_DATA_W = 8;
    localparam int IOX_ADDR_W = 12;
    localparam int IOX_SC_W   = 4;

    // Decoded I/O instruction strobes, one bit each
    typedef struct packed {
        logic inp;
        logic out;
        logic ski;
        logic sko;
        logic ion;
        logic iof;
    } io_ops_t;

    // Position inside the interrupt cycle
    typedef enum logic [1:0] {
        STEP_NONE    = 2'd0,
        STEP_CAPTURE = 2'd1,
        STEP_STORE   = 2'd2,
        STEP_RESUME  = 2'd3
    } irq_step_e;

    function automatic irq_step_e iox_step(input logic pend,
                                           input logic at_t0,
                                           input logic at_t1,
                                           input logic at_t2);
        irq_step_e s;
        s = STEP_NONE;
        if (pend) begin
            if (at_t0)      s = STEP_CAPTURE;
            else if (at_t1) s = STEP_STORE;
            else if (at_t2) s = STEP_RESUME;
        end
        return s;
    endfunction

endpackage

// File: rtl/iox_in_port.sv
module iox_in_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_valid,
    input  logic [DATA_W-1:0] dev_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= 1'b0;
            data_q <= '0;
        end else begin
            if (take) begin
                full <= 1'b0;
            end else if (dev_valid && !full) begin
                full   <= 1'b1;
                data_q <= dev_data;
            end
        end
    end

    // R2: a held byte is never overwritten
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (full && !take) |=> (full && $stable(data_q)));

    // R3: the input strobe empties the register
    assert_take_R3: assert property (@(posedge clk) disable iff (rst)
        take |=> !full);
endmodule

// File: rtl/iox_out_port.sv
module iox_out_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] ac_lo,
    input  logic              dev_ready,
    output logic              rdy,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy    <= 1'b1;
            data_q <= '0;
        end else begin
            if (load) begin
                rdy    <= 1'b0;
                data_q <= ac_lo;
            end else if (!rdy && dev_ready) begin
                rdy <= 1'b1;
            end
        end
    end

    // R4: the output strobe captures the accumulator byte
    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (!rdy && data_q == $past(ac_lo)));

    // R5: device acceptance frees the output register
    assert_accept_R5: assert property (@(posedge clk) disable iff (rst)
        (!rdy && dev_ready && !load) |=> rdy);
endmodule

// File: rtl/iox_irq_seq.sv
module iox_irq_seq
    import iox_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int SC_W     = 4,
    parameter int SAVE_LOC = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SC_W-1:0]   t_state,
    input  logic              ion,
    input  logic              iof,
    input  logic              flag_any,
    input  logic [ADDR_W-1:0] pc_cur,
    output logic              int_cycle,
    output logic              save_we,
    output logic [ADDR_W-1:0] save_addr,
    output logic [ADDR_W-1:0] save_data,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_load_val,
    output logic              seq_clr
);
    localparam logic [ADDR_W-1:0] SAVE_A   = ADDR_W'(SAVE_LOC);
    localparam logic [ADDR_W-1:0] RESUME_A = ADDR_W'(SAVE_LOC + 1);

    logic              en_q;
    logic              pend_q;
    logic [ADDR_W-1:0] ret_q;
    logic              at_t0, at_t1, at_t2, between;
    irq_step_e         step;

    assign at_t0   = (t_state == SC_W'(0));
    assign at_t1   = (t_state == SC_W'(1));
    assign at_t2   = (t_state == SC_W'(2));
    assign between = !(at_t0 || at_t1 || at_t2);
    assign step    = iox_step(pend_q, at_t0, at_t1, at_t2);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
            ret_q  <= '0;
        end else begin
            if (ion) en_q <= 1'b1;
            if (iof) en_q <= 1'b0;
            if (step == STEP_CAPTURE) ret_q <= pc_cur;
            if (step == STEP_RESUME) begin
                en_q   <= 1'b0;
                pend_q <= 1'b0;
            end else if (between && en_q && flag_any) begin
                pend_q <= 1'b1;
            end
        end
    end

    always_comb begin
        int_cycle   = pend_q;
        save_we     = (step == STEP_STORE);
        save_addr   = SAVE_A;
        save_data   = ret_q;
        pc_load     = (step == STEP_STORE) || (step == STEP_RESUME);
        pc_load_val = (step == STEP_RESUME) ? RESUME_A : SAVE_A;
        seq_clr     = (step == STEP_RESUME);
    end

    // R8: a request appears only between instructions with interrupts on
    assert_req_window_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> ($past(en_q) && $past(t_state) > SC_W'(2)));

    // R10: the last step leaves interrupts off and the cycle finished
    assert_exit_R10: assert property (@(posedge clk) disable iff (rst)
        (pend_q && at_t2) |=> (!pend_q && !en_q));

    // R7: enable strobes act on the enable bit
    assert_ion_R7: assert property (@(posedge clk) disable iff (rst)
        (ion && !iof && step != STEP_RESUME) |=> en_q);
    assert_iof_R7: assert property (@(posedge clk) disable iff (rst)
        iof |=> !en_q);
endmodule

// File: rtl/iox_ctrl.sv
module iox_ctrl
    import iox_pkg::*;
#(
    parameter int DATA_W   = IOX_DATA_W,
    parameter int ADDR_W   = IOX_ADDR_W,
    parameter int SC_W     = IOX_SC_W,
    parameter int SAVE_LOC = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SC_W-1:0]   t_state,
    input  logic              op_inp,
    input  logic              op_out,
    input  logic              op_ski,
    input  logic              op_sko,
    input  logic              op_ion,
    input  logic              op_iof,
    input  logic [DATA_W-1:0] ac_lo,
    input  logic [ADDR_W-1:0] pc_cur,
    output logic              skip_req,
    output logic [DATA_W-1:0] in_byte,
    output logic              int_cycle,
    output logic              save_we,
    output logic [ADDR_W-1:0] save_addr,
    output logic [ADDR_W-1:0] save_data,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_load_val,
    output logic              seq_clr,
    input  logic              dev_in_valid,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_out_ready
);
    io_ops_t ops;
    logic    in_full;
    logic    out_rdy;

    assign ops = '{inp: op_inp, out: op_out, ski: op_ski,
                   sko: op_sko, ion: op_ion, iof: op_iof};

    iox_in_port #(.DATA_W(DATA_W)) in_port_i (
        .clk      (clk),
        .rst      (rst),
        .dev_valid(dev_in_valid),
        .dev_data (dev_in_data),
        .take     (ops.inp),
        .full     (in_full),
        .data_q   (in_byte)
    );

    iox_out_port #(.DATA_W(DATA_W)) out_port_i (
        .clk      (clk),
        .rst      (rst),
        .load     (ops.out),
        .ac_lo    (ac_lo),
        .dev_ready(dev_out_ready),
        .rdy      (out_rdy),
        .data_q   (dev_out_data)
    );

    iox_irq_seq #(.ADDR_W(ADDR_W), .SC_W(SC_W), .SAVE_LOC(SAVE_LOC)) irq_i (
        .clk        (clk),
        .rst        (rst),
        .t_state    (t_state),
        .ion        (ops.ion),
        .iof        (ops.iof),
        .flag_any   (in_full || out_rdy),
        .pc_cur     (pc_cur),
        .int_cycle  (int_cycle),
        .save_we    (save_we),
        .save_addr  (save_addr),
        .save_data  (save_data),
        .pc_load    (pc_load),
        .pc_load_val(pc_load_val),
        .seq_clr    (seq_clr)
    );

    assign dev_in_ready  = !in_full;
    assign dev_out_valid = !out_rdy;
    assign skip_req      = (ops.ski && in_full) || (ops.sko && out_rdy);

    // R6: a skip is only ever requested by a test strobe
    assert_skip_src_R6: assert property (@(posedge clk) disable iff (rst)
        skip_req |-> (op_ski || op_sko));

    // R9: the return-address write happens only inside an interrupt cycle
    assert_save_R9: assert property (@(posedge clk) disable iff (rst)
        save_we |-> (int_cycle && pc_load && !seq_clr));
endmodule

// File: tb/iox_ctrl_tb.sv
module iox_ctrl_tb_top;
    localparam int DW = 8;
    localparam int AW = 12;
    localparam int SW = 4;

    typedef struct packed {
        logic [3:0]  t;
        logic [5:0]  ops;   // {inp,out,ski,sko,ion,iof}
        logic [7:0]  ac;
        logic [11:0] pc;
        logic        iv;
        logic [7:0]  id;
        logic        ordy;
        logic        e_skip;
        logic        e_we;
        logic [11:0] e_wd;
        logic        e_pcl;
        logic [11:0] e_pcv;
        logic        e_clr;
        logic        e_irdy;
        logic [7:0]  e_ib;
        logic        e_ov;
        logic [7:0]  e_od;
        logic        e_int;
        logic [3:0]  rq;
    } vec_t;

    localparam logic [5:0] NO  = 6'b000000;
    localparam logic [5:0] INP = 6'b100000;
    localparam logic [5:0] OUT = 6'b010000;
    localparam logic [5:0] SKI = 6'b001000;
    localparam logic [5:0] SKO = 6'b000100;
    localparam logic [5:0] ION = 6'b000010;
    localparam logic [5:0] IOF = 6'b000001;

    localparam int NV = 29;
    localparam vec_t VECS [0:NV-1] = '{
        '{4'd3, NO , 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 4'd1},  // R1 idle
        '{4'd3, SKI, 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 4'd6},  // R6 no input
        '{4'd3, SKO, 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 4'd6},  // R6 output free
        '{4'd3, NO , 8'h00, 12'h000, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 8'hA5, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 load
        '{4'd3, SKI, 8'h00, 12'h000, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 8'hA5, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 ignore
        '{4'd3, INP, 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'hA5, 1'b0, 8'h00, 1'b0, 4'd3},  // R3
        '{4'd3, NO , 8'h00, 12'h000, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 8'h3C, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 reload
        '{4'd3, INP, 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b0, 8'h00, 1'b0, 4'd3},  // R3
        '{4'd3, OUT, 8'h5A, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b1, 8'h5A, 1'b0, 4'd4},  // R4
        '{4'd3, SKO, 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b1, 8'h5A, 1'b0, 4'd6},  // R6 busy
        '{4'd3, NO , 8'h00, 12'h000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b0, 8'h5A, 1'b0, 4'd5},  // R5
        '{4'd4, NO , 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b0, 8'h5A, 1'b0, 4'd8},  // R8 disabled
        '{4'd3, ION, 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b0, 8'h5A, 1'b0, 4'd7},  // R7 on
        '{4'd0, NO , 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b0, 8'h5A, 1'b0, 4'd8},  // R8 T0 blocks
        '{4'd3, NO , 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b0, 8'h5A, 1'b1, 4'd8},  // R8 set
        '{4'd0, NO , 8'h00, 12'h123, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b0, 8'h5A, 1'b1, 4'd9},  // R9 T0
        '{4'd1, NO , 8'h00, 12'h124, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 12'h123, 1'b1, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b0, 8'h5A, 1'b1, 4'd9},  // R9 T1
        '{4'd2, NO , 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b1, 12'h001, 1'b1, 1'b1, 8'h3C, 1'b0, 8'h5A, 1'b0, 4'd10}, // R10 T2
        '{4'd3, NO , 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b0, 8'h5A, 1'b0, 4'd10}, // R10 no retrigger
        '{4'd3, ION, 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b0, 8'h5A, 1'b0, 4'd7},  // R7
        '{4'd0, IOF, 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b0, 8'h5A, 1'b0, 4'd7},  // R7 off
        '{4'd5, NO , 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b0, 8'h5A, 1'b0, 4'd7},  // R7 stays off
        '{4'd3, OUT, 8'h11, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b1, 8'h11, 1'b0, 4'd4},  // R4
        '{4'd3, ION, 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 8'h3C, 1'b1, 8'h11, 1'b0, 4'd7},  // R7 no flags
        '{4'd4, NO , 8'h00, 12'h000, 1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 8'h77, 1'b1, 8'h11, 1'b0, 4'd8},  // R8 flag arrives
        '{4'd4, NO , 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 8'h77, 1'b1, 8'h11, 1'b1, 4'd8},  // R8 input flag
        '{4'd0, NO , 8'h00, 12'h0AB, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 8'h77, 1'b1, 8'h11, 1'b1, 4'd9},  // R9
        '{4'd1, NO , 8'h00, 12'h0AB, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 12'h0AB, 1'b1, 12'h000, 1'b0, 1'b0, 8'h77, 1'b1, 8'h11, 1'b1, 4'd9},  // R9
        '{4'd2, NO , 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h000, 1'b1, 12'h001, 1'b1, 1'b0, 8'h77, 1'b1, 8'h11, 1'b0, 4'd10}  // R10
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] t_state = '0;
    logic          op_inp = 0, op_out = 0, op_ski = 0, op_sko = 0, op_ion = 0, op_iof = 0;
    logic [DW-1:0] ac_lo = '0;
    logic [AW-1:0] pc_cur = '0;
    logic          dev_in_valid = 0;
    logic [DW-1:0] dev_in_data = '0;
    logic          dev_out_ready = 0;
    logic          skip_req, int_cycle, save_we, pc_load, seq_clr;
    logic          dev_in_ready, dev_out_valid;
    logic [DW-1:0] in_byte, dev_out_data;
    logic [AW-1:0] save_addr, save_data, pc_load_val;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    iox_ctrl #(.DATA_W(DW), .ADDR_W(AW), .SC_W(SW), .SAVE_LOC(0)) dut_i (
        .clk(clk), .rst(rst), .t_state(t_state),
        .op_inp(op_inp), .op_out(op_out), .op_ski(op_ski), .op_sko(op_sko),
        .op_ion(op_ion), .op_iof(op_iof), .ac_lo(ac_lo), .pc_cur(pc_cur),
        .skip_req(skip_req), .in_byte(in_byte), .int_cycle(int_cycle),
        .save_we(save_we), .save_addr(save_addr), .save_data(save_data),
        .pc_load(pc_load), .pc_load_val(pc_load_val), .seq_clr(seq_clr),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
        .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
    );

    task automatic chk(input bit ok, input int rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] t, input logic [5:0] o,
                         input logic [7:0] ac, input logic [11:0] pc,
                         input logic iv, input logic [7:0] id, input logic ordy);
        t_state = t;
        {op_inp, op_out, op_ski, op_sko, op_ion, op_iof} = o;
        ac_lo = ac; pc_cur = pc;
        dev_in_valid = iv; dev_in_data = id; dev_out_ready = ordy;
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        drive(v.t, v.ops, v.ac, v.pc, v.iv, v.id, v.ordy);
        #2;
        chk(skip_req == v.e_skip, int'(v.rq), "skip_req", int'(skip_req), int'(v.e_skip));
        chk(save_we == v.e_we, int'(v.rq), "save_we", int'(save_we), int'(v.e_we));
        if (v.e_we) begin
            chk(save_data == v.e_wd, int'(v.rq), "save_data", int'(save_data), int'(v.e_wd));
            chk(save_addr == 12'h000, int'(v.rq), "save_addr", int'(save_addr), 0);
        end
        chk(pc_load == v.e_pcl, int'(v.rq), "pc_load", int'(pc_load), int'(v.e_pcl));
        if (v.e_pcl)
            chk(pc_load_val == v.e_pcv, int'(v.rq), "pc_load_val", int'(pc_load_val), int'(v.e_pcv));
        chk(seq_clr == v.e_clr, int'(v.rq), "seq_clr", int'(seq_clr), int'(v.e_clr));
        @(posedge clk);
        #1;
        chk(dev_in_ready == v.e_irdy, int'(v.rq), "dev_in_ready", int'(dev_in_ready), int'(v.e_irdy));
        chk(in_byte == v.e_ib, int'(v.rq), "in_byte", int'(in_byte), int'(v.e_ib));
        chk(dev_out_valid == v.e_ov, int'(v.rq), "dev_out_valid", int'(dev_out_valid), int'(v.e_ov));
        chk(dev_out_data == v.e_od, int'(v.rq), "dev_out_data", int'(dev_out_data), int'(v.e_od));
        chk(int_cycle == v.e_int, int'(v.rq), "int_cycle", int'(int_cycle), int'(v.e_int));
    endtask

    initial begin : watchdog
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(dev_in_ready == 1'b1, 1, "dev_in_ready", int'(dev_in_ready), 1);
        chk(dev_out_valid == 1'b0, 1, "dev_out_valid", int'(dev_out_valid), 0);
        chk(int_cycle == 1'b0, 1, "int_cycle", int'(int_cycle), 0);

        for (int i = 0; i < NV; i++) apply(VECS[i]);

        // R4: output strobe beats a same-cycle device acceptance
        @(negedge clk);
        drive(4'd3, OUT, 8'hC3, 12'h000, 1'b0, 8'h00, 1'b1);
        @(posedge clk); #1;
        chk(dev_out_valid == 1'b1, 4, "dev_out_valid", int'(dev_out_valid), 1);
        chk(dev_out_data == 8'hC3, 4, "dev_out_data", int'(dev_out_data), 'hC3);

        // R1: reset mid-run with both flags in non-reset state
        @(negedge clk);
        drive(4'd3, NO, 8'h00, 12'h000, 1'b0, 8'h00, 1'b0);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(dev_in_ready == 1'b1, 1, "dev_in_ready after reset", int'(dev_in_ready), 1);
        chk(dev_out_valid == 1'b0, 1, "dev_out_valid after reset", int'(dev_out_valid), 0);
        chk(int_cycle == 1'b0, 1, "int_cycle after reset", int'(int_cycle), 0);
        drive(4'd3, SKO, 8'h00, 12'h000, 1'b0, 8'h00, 1'b0);
        #1;
        chk(skip_req == 1'b1, 1, "skip_req on output flag", int'(skip_req), 1);
        // R1: enable is off after reset, so the raised output flag starts nothing
        @(posedge clk); #1;
        chk(int_cycle == 1'b0, 1, "int_cycle enable off", int'(int_cycle), 0);
        @(negedge clk);
        drive(4'd3, NO, 8'h00, 12'h000, 1'b0, 8'h00, 1'b0);
        @(posedge clk); #1;
        chk(int_cycle == 1'b0, 1, "int_cycle enable off", int'(int_cycle), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule